// File: doc/BRIEF.md
# Wishbone Crossbar Interconnect

This block joins a set of Wishbone initiator ports to a set of Wishbone target ports so that several initiators can work at once, each with a different target. Every target owns an address window given by an inclusive lower and upper bound on two static input vectors. Each initiator's address is compared with every window. A separate arbiter for each target then chooses one of the initiators that point at it.

A target's grant is held for the whole bus cycle. It lasts as long as the chosen initiator keeps CYC high, and it passes to another initiator only after that cycle ends. The target sees the request fields of its granted initiator and nothing else. A target response goes back only to the initiator that holds the grant on that target. Initiators without a path see an all-zero response. Targets without an owner see an all-zero request.

Per-port signals arrive as flat vectors. Port k of a field of width W sits at bits [k*W +: W]. All arbiter state is held in registers with an asynchronous active-low reset.

Top module: `wb_xbar`

## Requirements
- R1: An initiator requests target t only while its CYC and STB are both 1 and its address lies between the base and the limit of window t, inclusive at both ends. An address outside every window reaches no target.
- R2: A grant is registered. An initiator that starts requesting a free target in cycle c appears on that target's outputs from cycle c+1.
- R3: While the granted initiator keeps CYC at 1, the grant of that target does not move, whatever the other initiators request.
- R4: The edge that follows a cycle in which the owner has CYC at 0 releases the grant. At that same edge the arbiter grants any initiator that is then requesting, so the new owner is visible one cycle after the drop.
- R5: When two or more initiators request a free target at the same edge, the lowest-numbered one receives the grant.
- R6: The response of a target (read data, read tag, ACK, ERR) reaches only the initiator that holds its grant and is currently addressing it. Different initiators can receive responses from different targets in the same cycle.
- R7: An initiator with no granted, addressed target sees read data 0, read tag 0, ACK 0 and ERR 0.
- R8: A target whose owner is absent or has CYC at 0 sees every request output at 0: address, tags, CTI, BTE, write data, SEL, CYC, STB and WE.
- R9: Asserting reset clears every grant at once. After reset, no target sees CYC until a new request has been registered.
- R10: The owner's address, write data, write tag, address tag, cycle tag, SEL, WE, CTI and BTE are passed unchanged to the target.
- R11: A target sees STB only while its owner's current address is still inside its window. If the owner moves to another window while keeping CYC, the target sees CYC at 1 and STB at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_base | input | NT*AW | Lower bound of each target window, inclusive |
| win_limit | input | NT*AW | Upper bound of each target window, inclusive |
| ini_adr | input | NI*AW | Initiator addresses |
| ini_tga | input | NI*TGAW | Initiator address tags |
| ini_cti | input | NI*3 | Initiator cycle type identifiers |
| ini_bte | input | NI*2 | Initiator burst type extensions |
| ini_dat_w | input | NI*DW | Initiator write data |
| ini_tgd_w | input | NI*TGDW | Initiator write data tags |
| ini_cyc | input | NI | Initiator bus cycle flags |
| ini_tgc | input | NI*TGCW | Initiator cycle tags |
| ini_sel | input | NI*DW/8 | Initiator byte selects |
| ini_stb | input | NI | Initiator strobes |
| ini_we | input | NI | Initiator write enables |
| ini_dat_r | output | NI*DW | Read data returned to each initiator |
| ini_tgd_r | output | NI*TGDW | Read tag returned to each initiator |
| ini_err | output | NI | Error returned to each initiator |
| ini_ack | output | NI | Acknowledge returned to each initiator |
| tgt_adr | output | NT*AW | Address to each target |
| tgt_tga | output | NT*TGAW | Address tag to each target |
| tgt_cti | output | NT*3 | Cycle type to each target |
| tgt_bte | output | NT*2 | Burst type to each target |
| tgt_dat_w | output | NT*DW | Write data to each target |
| tgt_tgd_w | output | NT*TGDW | Write tag to each target |
| tgt_cyc | output | NT | Bus cycle flag to each target |
| tgt_tgc | output | NT*TGCW | Cycle tag to each target |
| tgt_sel | output | NT*DW/8 | Byte selects to each target |
| tgt_stb | output | NT | Strobe to each target |
| tgt_we | output | NT | Write enable to each target |
| tgt_dat_r | input | NT*DW | Read data from each target |
| tgt_tgd_r | input | NT*TGDW | Read tag from each target |
| tgt_err | input | NT | Error from each target |
| tgt_ack | input | NT | Acknowledge from each target |

## Verification
Two things can happen at the same edge: the owner of a target lets its grant go, and a waiting initiator takes that grant. The bench provokes this by holding both initiators on one window and lowering CYC on the first. It checks that the target goes fully idle for exactly one cycle and then shows the second initiator's address. A second overlap comes from two initiators being served by two different targets in one cycle, each acknowledging with different data and error values. The monitor checks that each response lands on its own initiator, with no leakage between them.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int CTI_W = 3;
    localparam int BTE_W = 2;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
    parameter int AW = 32,
    parameter int NT = 4
) (
    input  logic [AW-1:0]    adr,
    input  logic             cyc,
    input  logic             stb,
    input  logic [NT*AW-1:0] base_flat,
    input  logic [NT*AW-1:0] limit_flat,
    output logic [NT-1:0]    hit
);

    logic active;
    assign active = cyc & stb;

    // One comparator pair per window; bounds are inclusive.
    for (genvar t = 0; t < NT; t++) begin : g_win
        logic above_base;
        logic below_limit;
        assign above_base  = (adr >= base_flat[t*AW +: AW]);
        assign below_limit = (adr <= limit_flat[t*AW +: AW]);
        assign hit[t]      = active & above_base & below_limit;
    end

endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter
    import xbar_pkg::*;
#(
    parameter int NI = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NI-1:0] req,
    input  logic [NI-1:0] cyc,
    output logic [NI-1:0] gnt
);

    typedef struct packed {
        arb_state_e    st;
        logic [NI-1:0] gnt;
    } arb_reg_t;

    arb_reg_t state_d;
    arb_reg_t state_q;
    logic     hold_d;

    always_comb begin
        state_d = state_q;
        hold_d  = (state_q.st == ARB_HELD) && (|(state_q.gnt & cyc));
        if (!hold_d) begin
            state_d.st  = ARB_FREE;
            state_d.gnt = '0;
            // Descending scan so the lowest requesting index is kept last.
            for (int i = NI - 1; i >= 0; i--) begin
                if (req[i]) begin
                    state_d.gnt    = '0;
                    state_d.gnt[i] = 1'b1;
                    state_d.st     = ARB_HELD;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{st: ARB_FREE, gnt: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign gnt = state_q.gnt;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(state_q.gnt)) else $error("grant not one-hot"); // R5

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(state_q.gnt & cyc)) |=> $stable(state_q.gnt)) else $error("grant moved while owner active"); // R3

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(state_q.gnt & cyc)) |=> (state_q.gnt == ($past(req) & (~$past(req) + 1'b1))))
        else $error("free target not given to lowest requester"); // R4

endmodule

// File: rtl/xbar_andor.sv
module xbar_andor #(
    parameter int N = 2,
    parameter int W = 8
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] din,
    output logic [W-1:0]   dout
);

    // AND-OR selection: all zero when no select bit is set.
    always_comb begin
        dout = '0;
        for (int k = 0; k < N; k++) begin
            if (sel[k]) begin
                dout = dout | din[k*W +: W];
            end
        end
    end

endmodule

// File: rtl/wb_xbar.sv
module wb_xbar
    import xbar_pkg::*;
#(
    parameter int NI   = 2,
    parameter int NT   = 4,
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int TGAW = 1,
    parameter int TGDW = 1,
    parameter int TGCW = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT*AW-1:0]     win_base,
    input  logic [NT*AW-1:0]     win_limit,
    input  logic [NI*AW-1:0]     ini_adr,
    input  logic [NI*TGAW-1:0]   ini_tga,
    input  logic [NI*3-1:0]      ini_cti,
    input  logic [NI*2-1:0]      ini_bte,
    input  logic [NI*DW-1:0]     ini_dat_w,
    input  logic [NI*TGDW-1:0]   ini_tgd_w,
    input  logic [NI-1:0]        ini_cyc,
    input  logic [NI*TGCW-1:0]   ini_tgc,
    input  logic [NI*DW/8-1:0]   ini_sel,
    input  logic [NI-1:0]        ini_stb,
    input  logic [NI-1:0]        ini_we,
    output logic [NI*DW-1:0]     ini_dat_r,
    output logic [NI*TGDW-1:0]   ini_tgd_r,
    output logic [NI-1:0]        ini_err,
    output logic [NI-1:0]        ini_ack,
    output logic [NT*AW-1:0]     tgt_adr,
    output logic [NT*TGAW-1:0]   tgt_tga,
    output logic [NT*3-1:0]      tgt_cti,
    output logic [NT*2-1:0]      tgt_bte,
    output logic [NT*DW-1:0]     tgt_dat_w,
    output logic [NT*TGDW-1:0]   tgt_tgd_w,
    output logic [NT-1:0]        tgt_cyc,
    output logic [NT*TGCW-1:0]   tgt_tgc,
    output logic [NT*DW/8-1:0]   tgt_sel,
    output logic [NT-1:0]        tgt_stb,
    output logic [NT-1:0]        tgt_we,
    input  logic [NT*DW-1:0]     tgt_dat_r,
    input  logic [NT*TGDW-1:0]   tgt_tgd_r,
    input  logic [NT-1:0]        tgt_err,
    input  logic [NT-1:0]        tgt_ack
);

    localparam int SW    = DW / 8;
    localparam int REQ_W = AW + TGAW + CTI_W + BTE_W + DW + TGDW + TGCW + SW + 1;
    localparam int RSP_W = DW + TGDW + 2;

    logic [NT-1:0]           hit_ini    [NI];
    logic [NI-1:0]           gnt_tgt    [NT];
    logic [NI-1:0]           own_live   [NT];
    logic [NT-1:0][NI-1:0]   hit_by_tgt;
    logic [NI-1:0][NT-1:0]   route_ini;
    logic [NI*REQ_W-1:0]     req_flat;
    logic [NT*RSP_W-1:0]     rsp_flat;
    logic [REQ_W-1:0]        tgt_rec    [NT];
    logic [RSP_W-1:0]        ini_rec    [NI];

    // Per-initiator decode and request packing.
    for (genvar i = 0; i < NI; i++) begin : g_ini
        xbar_decode #(
            .AW (AW),
            .NT (NT)
        ) u_decode (
            .adr        (ini_adr[i*AW +: AW]),
            .cyc        (ini_cyc[i]),
            .stb        (ini_stb[i]),
            .base_flat  (win_base),
            .limit_flat (win_limit),
            .hit        (hit_ini[i])
        );

        assign req_flat[i*REQ_W +: REQ_W] = {
            ini_adr[i*AW +: AW],
            ini_tga[i*TGAW +: TGAW],
            ini_cti[i*CTI_W +: CTI_W],
            ini_bte[i*BTE_W +: BTE_W],
            ini_dat_w[i*DW +: DW],
            ini_tgd_w[i*TGDW +: TGDW],
            ini_tgc[i*TGCW +: TGCW],
            ini_sel[i*SW +: SW],
            ini_we[i]
        };

        xbar_andor #(
            .N (NT),
            .W (RSP_W)
        ) u_rsp_mux (
            .sel  (route_ini[i]),
            .din  (rsp_flat),
            .dout (ini_rec[i])
        );

        assign {ini_dat_r[i*DW +: DW], ini_tgd_r[i*TGDW +: TGDW], ini_err[i], ini_ack[i]} = ini_rec[i];

        AST_ACK_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
            ini_ack[i] |-> (|(tgt_ack & tgt_cyc & tgt_stb))) else $error("ack without active target"); // R6
    end

    // Transpose decode results and build the response routes.
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            for (int i = 0; i < NI; i++) begin
                hit_by_tgt[t][i] = hit_ini[i][t];
                route_ini[i][t]  = gnt_tgt[t][i] & hit_ini[i][t];
            end
        end
    end

    // Per-target arbitration and request forwarding.
    for (genvar t = 0; t < NT; t++) begin : g_tgt
        xbar_arbiter #(
            .NI (NI)
        ) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (hit_by_tgt[t]),
            .cyc   (ini_cyc),
            .gnt   (gnt_tgt[t])
        );

        assign own_live[t] = gnt_tgt[t] & ini_cyc;

        xbar_andor #(
            .N (NI),
            .W (REQ_W)
        ) u_req_mux (
            .sel  (own_live[t]),
            .din  (req_flat),
            .dout (tgt_rec[t])
        );

        assign {
            tgt_adr[t*AW +: AW],
            tgt_tga[t*TGAW +: TGAW],
            tgt_cti[t*CTI_W +: CTI_W],
            tgt_bte[t*BTE_W +: BTE_W],
            tgt_dat_w[t*DW +: DW],
            tgt_tgd_w[t*TGDW +: TGDW],
            tgt_tgc[t*TGCW +: TGCW],
            tgt_sel[t*SW +: SW],
            tgt_we[t]
        } = tgt_rec[t];

        assign tgt_cyc[t] = |own_live[t];
        assign tgt_stb[t] = |(gnt_tgt[t] & hit_by_tgt[t]);

        assign rsp_flat[t*RSP_W +: RSP_W] = {
            tgt_dat_r[t*DW +: DW],
            tgt_tgd_r[t*TGDW +: TGDW],
            tgt_err[t],
            tgt_ack[t]
        };

        AST_IDLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
            !tgt_cyc[t] |-> (!tgt_stb[t] && !tgt_we[t] && tgt_adr[t*AW +: AW] == '0
                             && tgt_sel[t*SW +: SW] == '0 && tgt_dat_w[t*DW +: DW] == '0))
            else $error("idle target sees request fields"); // R8

        AST_STB_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            tgt_stb[t] |-> (tgt_cyc[t] && tgt_adr[t*AW +: AW] >= win_base[t*AW +: AW]
                            && tgt_adr[t*AW +: AW] <= win_limit[t*AW +: AW]))
            else $error("strobe outside window"); // R11
    end

endmodule

// File: tb/wb_xbar_bench.sv
module wb_xbar_bench;

    localparam int NI = 2;
    localparam int NT = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    localparam int K_TCYC  = 0;
    localparam int K_TSTB  = 1;
    localparam int K_TADR  = 2;
    localparam int K_TDATW = 3;
    localparam int K_TMISC = 4;
    localparam int K_IACK  = 5;
    localparam int K_IERR  = 6;
    localparam int K_IDATR = 7;

    typedef struct {
        string       rq;
        int          kind;
        int          idx;
        logic [31:0] exp;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT*AW-1:0]   win_base;
    logic [NT*AW-1:0]   win_limit;
    logic [NI*AW-1:0]   ini_adr = '0;
    logic [NI-1:0]      ini_tga = '0;
    logic [NI*3-1:0]    ini_cti = '0;
    logic [NI*2-1:0]    ini_bte = '0;
    logic [NI*DW-1:0]   ini_dat_w = '0;
    logic [NI-1:0]      ini_tgd_w = '0;
    logic [NI-1:0]      ini_cyc = '0;
    logic [NI-1:0]      ini_tgc = '0;
    logic [NI*SW-1:0]   ini_sel = '0;
    logic [NI-1:0]      ini_stb = '0;
    logic [NI-1:0]      ini_we = '0;
    logic [NI*DW-1:0]   ini_dat_r;
    logic [NI-1:0]      ini_tgd_r;
    logic [NI-1:0]      ini_err;
    logic [NI-1:0]      ini_ack;
    logic [NT*AW-1:0]   tgt_adr;
    logic [NT-1:0]      tgt_tga;
    logic [NT*3-1:0]    tgt_cti;
    logic [NT*2-1:0]    tgt_bte;
    logic [NT*DW-1:0]   tgt_dat_w;
    logic [NT-1:0]      tgt_tgd_w;
    logic [NT-1:0]      tgt_cyc;
    logic [NT-1:0]      tgt_tgc;
    logic [NT*SW-1:0]   tgt_sel;
    logic [NT-1:0]      tgt_stb;
    logic [NT-1:0]      tgt_we;
    logic [NT*DW-1:0]   tgt_dat_r = '0;
    logic [NT-1:0]      tgt_tgd_r = '0;
    logic [NT-1:0]      tgt_err = '0;
    logic [NT-1:0]      tgt_ack = '0;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    sb_item_t sb_q[$];
    sb_item_t cur;

    always #5 clk = ~clk;

    wb_xbar #(
        .NI (NI), .NT (NT), .AW (AW), .DW (DW), .TGAW (1), .TGDW (1), .TGCW (1)
    ) u_wb_xbar (
        .clk (clk), .rst_n (rst_n), .win_base (win_base), .win_limit (win_limit),
        .ini_adr (ini_adr), .ini_tga (ini_tga), .ini_cti (ini_cti), .ini_bte (ini_bte),
        .ini_dat_w (ini_dat_w), .ini_tgd_w (ini_tgd_w), .ini_cyc (ini_cyc), .ini_tgc (ini_tgc),
        .ini_sel (ini_sel), .ini_stb (ini_stb), .ini_we (ini_we),
        .ini_dat_r (ini_dat_r), .ini_tgd_r (ini_tgd_r), .ini_err (ini_err), .ini_ack (ini_ack),
        .tgt_adr (tgt_adr), .tgt_tga (tgt_tga), .tgt_cti (tgt_cti), .tgt_bte (tgt_bte),
        .tgt_dat_w (tgt_dat_w), .tgt_tgd_w (tgt_tgd_w), .tgt_cyc (tgt_cyc), .tgt_tgc (tgt_tgc),
        .tgt_sel (tgt_sel), .tgt_stb (tgt_stb), .tgt_we (tgt_we),
        .tgt_dat_r (tgt_dat_r), .tgt_tgd_r (tgt_tgd_r), .tgt_err (tgt_err), .tgt_ack (tgt_ack)
    );

    // Misc field packing used by the checks: {tga, tgc, we, sel[3:0], bte[1:0], cti[2:0]}.
    function automatic logic [31:0] misc_word(logic tga, logic tgc, logic we,
                                              logic [3:0] sel, logic [1:0] bte, logic [2:0] cti);
        return {20'd0, tga, tgc, we, sel, bte, cti};
    endfunction

    function automatic logic [31:0] probe(int kind, int idx);
        case (kind)
            K_TCYC:  return {28'd0, tgt_cyc};
            K_TSTB:  return {28'd0, tgt_stb};
            K_TADR:  return tgt_adr[idx*AW +: AW];
            K_TDATW: return tgt_dat_w[idx*DW +: DW];
            K_TMISC: return misc_word(tgt_tga[idx], tgt_tgc[idx], tgt_we[idx],
                                      tgt_sel[idx*SW +: SW], tgt_bte[idx*2 +: 2], tgt_cti[idx*3 +: 3]);
            K_IACK:  return {30'd0, ini_ack};
            K_IERR:  return {30'd0, ini_err};
            K_IDATR: return ini_dat_r[idx*DW +: DW];
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic expect_at(string rq, int kind, int idx, logic [31:0] v);
        sb_item_t it;
        it.rq = rq; it.kind = kind; it.idx = idx; it.exp = v;
        sb_q.push_back(it);
    endtask

    // Monitor: evaluates every expectation queued for this cycle.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            n_checks++;
            if (probe(cur.kind, cur.idx) !== cur.exp) begin
                n_errors++;
                $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                         cur.rq, cur.kind, cur.idx, probe(cur.kind, cur.idx), cur.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic ini_full(int i, logic [31:0] adr, logic we, logic [31:0] dat,
                            logic [2:0] cti, logic [1:0] bte, logic [3:0] sel, logic tga, logic tgc);
        ini_adr[i*AW +: AW]   = adr;
        ini_we[i]             = we;
        ini_dat_w[i*DW +: DW] = dat;
        ini_cti[i*3 +: 3]     = cti;
        ini_bte[i*2 +: 2]     = bte;
        ini_sel[i*SW +: SW]   = sel;
        ini_tga[i]            = tga;
        ini_tgc[i]            = tgc;
        ini_cyc[i]            = 1'b1;
        ini_stb[i]            = 1'b1;
    endtask

    task automatic ini_go(int i, logic [31:0] adr);
        ini_full(i, adr, 1'b0, 32'h0, 3'd0, 2'd0, 4'hF, 1'b0, 1'b0);
    endtask

    task automatic ini_off(int i);
        ini_cyc[i] = 1'b0;
        ini_stb[i] = 1'b0;
    endtask

    task automatic tgt_rsp(int t, logic ack, logic err, logic [31:0] dat);
        tgt_ack[t]            = ack;
        tgt_err[t]            = err;
        tgt_dat_r[t*DW +: DW] = dat;
    endtask

    task automatic window_probe(logic [31:0] adr, logic [3:0] mask);
        step(); ini_go(0, adr);
        step(); expect_at("R1 window decode", K_TCYC, 0, {28'd0, mask});
        step(); ini_off(0);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) begin
            win_base[t*AW +: AW]  = 32'(t) * 32'h1000;
            win_limit[t*AW +: AW] = 32'(t) * 32'h1000 + 32'h0FFF;
        end
        // Reset state
        step(); expect_at("R9 reset cyc", K_TCYC, 0, 0); expect_at("R9 reset ack", K_IACK, 0, 0);
        step(); rst_n = 1'b1;

        // Single write with full field pass-through
        step(); ini_full(0, 32'h1004, 1'b1, 32'hDEAD_BEEF, 3'd2, 2'd1, 4'hF, 1'b1, 1'b0);
        expect_at("R2 not yet granted", K_TCYC, 0, 0);
        step(); tgt_rsp(1, 1'b1, 1'b0, 32'h5555_0001);
        expect_at("R2 granted", K_TCYC, 0, 32'h2);
        expect_at("R10 address", K_TADR, 1, 32'h1004);
        expect_at("R10 write data", K_TDATW, 1, 32'hDEAD_BEEF);
        expect_at("R10 misc fields", K_TMISC, 1, misc_word(1'b1, 1'b0, 1'b1, 4'hF, 2'd1, 3'd2));
        expect_at("R6 ack routed", K_IACK, 0, 32'h1);
        expect_at("R6 data routed", K_IDATR, 0, 32'h5555_0001);
        expect_at("R7 other parked", K_IDATR, 1, 32'h0);
        step(); ini_off(0); tgt_rsp(1, 1'b0, 1'b0, 32'h0);
        expect_at("R8 idle cyc", K_TCYC, 0, 0);
        expect_at("R8 idle adr", K_TADR, 1, 0);
        expect_at("R8 idle misc", K_TMISC, 1, 0);

        // Inclusive window boundaries
        window_probe(32'h0000_0FFF, 4'b0001);
        window_probe(32'h0000_1000, 4'b0010);
        window_probe(32'h0000_2FFF, 4'b0100);
        window_probe(32'h0000_3FFF, 4'b1000);
        // Unmapped address with a stray target ack
        step(); ini_go(0, 32'h0000_4000); tgt_rsp(2, 1'b1, 1'b1, 32'h99);
        step(); expect_at("R1 unmapped", K_TCYC, 0, 0);
        expect_at("R7 parked ack", K_IACK, 0, 0);
        expect_at("R7 parked err", K_IERR, 0, 0);
        expect_at("R7 parked data", K_IDATR, 0, 0);
        step(); ini_off(0); tgt_rsp(2, 1'b0, 1'b0, 32'h0);

        // Contention, lock, release and handover
        step(); ini_go(0, 32'h2010); ini_go(1, 32'h2020);
        step(); tgt_rsp(2, 1'b1, 1'b0, 32'h77);
        expect_at("R5 lowest wins", K_TADR, 2, 32'h2010);
        expect_at("R6 ack to owner only", K_IACK, 0, 32'h1);
        expect_at("R7 loser parked", K_IDATR, 1, 32'h0);
        step(); tgt_rsp(2, 1'b0, 1'b0, 32'h0);
        expect_at("R3 lock kept", K_TADR, 2, 32'h2010);
        step(); ini_off(0);
        expect_at("R4 owner dropped", K_TCYC, 0, 0);
        step(); expect_at("R4 handover", K_TADR, 2, 32'h2020);
        expect_at("R4 handover cyc", K_TCYC, 0, 32'h4);
        step(); ini_go(0, 32'h2030);
        expect_at("R3 higher priority waits", K_TADR, 2, 32'h2020);
        step(); expect_at("R3 still held", K_TADR, 2, 32'h2020);
        step(); ini_off(1);
        expect_at("R4 owner dropped again", K_TCYC, 0, 0);
        step(); expect_at("R4 waiter granted", K_TADR, 2, 32'h2030);
        step(); ini_off(0);

        // Two targets serving two initiators at once
        step(); ini_go(0, 32'h0040); ini_go(1, 32'h3040);
        step(); tgt_rsp(0, 1'b1, 1'b0, 32'hA0); tgt_rsp(3, 1'b1, 1'b1, 32'hB3);
        expect_at("R6 both targets", K_TCYC, 0, 32'h9);
        expect_at("R6 both acks", K_IACK, 0, 32'h3);
        expect_at("R6 err to initiator 1", K_IERR, 0, 32'h2);
        expect_at("R6 data to initiator 0", K_IDATR, 0, 32'hA0);
        expect_at("R6 data to initiator 1", K_IDATR, 1, 32'hB3);
        step(); tgt_rsp(0, 1'b0, 1'b0, 32'h0); tgt_rsp(3, 1'b0, 1'b0, 32'h0);
        ini_off(0); ini_off(1);

        // Owner leaves the window while keeping CYC
        step(); ini_go(0, 32'h1100);
        step(); expect_at("R11 strobe in window", K_TSTB, 0, 32'h2);
        step(); ini_go(0, 32'h0100);
        expect_at("R11 cyc kept", K_TCYC, 0, 32'h2);
        expect_at("R11 strobe dropped", K_TSTB, 0, 32'h0);
        step(); expect_at("R11 both held", K_TCYC, 0, 32'h3);
        expect_at("R11 new strobe", K_TSTB, 0, 32'h1);
        expect_at("R10 new address", K_TADR, 0, 32'h0100);
        step(); ini_off(0);

        // Reset in the middle of a cycle
        step(); ini_go(1, 32'h1200);
        step(); expect_at("R9 before reset", K_TCYC, 0, 32'h2);
        step(); rst_n = 1'b0;
        expect_at("R9 reset clears", K_TCYC, 0, 0);
        step(); rst_n = 1'b1;
        expect_at("R9 no grant after reset", K_TCYC, 0, 0);
        step(); expect_at("R9 regranted", K_TCYC, 0, 32'h2);
        step(); ini_off(1);
        step(); step();
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (done || cycles > 5000) begin
            if (!done) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            end
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule